// File: doc/BRIEF.md
# Keyboard Command Responder

This block is the keyboard-side interpreter for host commands. The controller hands it command bytes over a valid/ready handshake. The block answers each one with response bytes on a second valid/ready handshake. It holds the keyboard's own settings:

- three lock-indicator bits,
- a seven-bit repeat rate/delay code,
- an enable flag,
- the most recently accepted scancode, which the resend command replays.

Two commands need a parameter byte, so the block keeps a pending-argument state between the command and its parameter. The key-matrix side delivers scancodes on a plain valid/data input. A scancode is queued behind any command responses from the same cycle, or it is dropped. The serial line and repeat timing are not part of this block.

All responses leave through one in-order queue, which holds `DEPTH` bytes. A command is accepted only when the queue has room for the longest answer a command can produce.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset no response is pending, `leds` is 000, `typematic` equals `DEF_RATE`, `kbd_enabled` is 1, `cmd_ready` is 1 and the stored scancode is 0x00.
- R2: Byte 0xED followed by a byte below 0xED sets `leds` to bits [2:0] of the second byte (bit 2 caps, bit 1 num, bit 0 scroll); each of the two bytes is answered with 0xFA.
- R3: Byte 0xF3 followed by a byte below 0xED sets `typematic` to bits [6:0] of the second byte (bit 7 is ignored); each byte is answered with 0xFA.
- R4: Byte 0xEE is answered with 0xEE alone and changes no state.
- R5: 0xF4 sets `kbd_enabled`. 0xF5 clears it and restores `typematic` to `DEF_RATE`. 0xF6 restores `typematic` without touching the enable flag. None of the three alters `leds`, and each is answered with 0xFA.
- R6: Bytes 0xEF–0xF2 and 0xF7–0xFD are answered with 0xFA and change nothing. A byte below 0xED with no parameter pending is answered with 0xFA and has no effect.
- R7: 0xFE is answered with the stored last scancode only, and no 0xFA is sent.
- R8: 0xFF is answered with 0xFA then 0xAA. It sets `leds` to 000, `typematic` to `DEF_RATE`, the enable flag to 1 and the stored scancode to 0x00, and it clears any pending parameter.
- R9: A byte of 0xED or above that arrives while a parameter is pending is decoded as a new command, and the pending command is abandoned.
- R10: A scancode is accepted only when the block is enabled and the queue still has a free slot after that cycle's command responses. An accepted scancode is queued after those responses and becomes the stored scancode. Otherwise it is dropped and the stored scancode is unchanged.
- R11: Responses leave in the order they were queued, one per cycle while `rsp_valid` and `rsp_ready` are both high, and `rsp_data` holds steady while stalled. `cmd_ready` is high exactly when at least two slots are free, counted before that cycle's pop.
- R12: A change of the enable flag governs scancode acceptance from the following cycle on. A scancode arriving together with 0xF5 is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command/parameter byte offered |
| cmd_data | input | 8 | Command or parameter byte |
| cmd_ready | output | 1 | Block can take a byte this cycle |
| rsp_valid | output | 1 | Response byte available |
| rsp_data | output | 8 | Response byte at queue head |
| rsp_ready | input | 1 | Consumer takes the head byte |
| scan_valid | input | 1 | Scancode offered this cycle |
| scan_data | input | 8 | Scancode byte |
| leds | output | 3 | Lock indicators: caps, num, scroll (bit 2..0) |
| typematic | output | RATE_W | Repeat rate/delay code |
| kbd_enabled | output | 1 | Scancode reporting enabled |

## Verification
The bench builds the block with `DEPTH` = 4 and the default `DEF_RATE` of 0x2B. The shallow queue fills within a few cycles of stalled consumption. That quickly brings within reach the cases where `cmd_ready` falls and scancodes are dropped for lack of room. It also reaches the two-byte reset answer landing next to a scancode in the same cycle, and the ordering of wrapped queue entries. A default rate that is not zero makes every restore of defaults visible on `typematic`.

// File: rtl/kbd_cmd_pkg.sv
`timescale 1ns/1ps
package kbd_cmd_pkg;

    // Pending parameter kinds
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_LED  = 2'd1,
        PEND_RATE = 2'd2
    } pend_e;

    // Decoded actions
    typedef enum logic [3:0] {
        OP_LED_ARG,
        OP_RATE_ARG,
        OP_SET_LED,
        OP_SET_RATE,
        OP_ECHO,
        OP_NOP,
        OP_ENABLE,
        OP_DISABLE,
        OP_DEFAULTS,
        OP_RESEND,
        OP_RESET,
        OP_STRAY
    } op_e;

    localparam logic [7:0] CMD_FLOOR    = 8'hED;
    localparam logic [7:0] CMD_SET_LED  = 8'hED;
    localparam logic [7:0] CMD_ECHO     = 8'hEE;
    localparam logic [7:0] CMD_SET_RATE = 8'hF3;
    localparam logic [7:0] CMD_ENABLE   = 8'hF4;
    localparam logic [7:0] CMD_DISABLE  = 8'hF5;
    localparam logic [7:0] CMD_DEFAULTS = 8'hF6;
    localparam logic [7:0] CMD_RESEND   = 8'hFE;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

    localparam logic [7:0] RSP_ACK  = 8'hFA;
    localparam logic [7:0] RSP_ECHO = 8'hEE;
    localparam logic [7:0] RSP_BAT  = 8'hAA;

    localparam int LED_W    = 3;
    localparam int MAX_PUSH = 3;   // two command answers plus one scancode

endpackage

// File: rtl/kbd_cmd_decode.sv
`timescale 1ns/1ps
module kbd_cmd_decode
    import kbd_cmd_pkg::*;
(
    input  logic [7:0] byte_i,
    input  pend_e      pend_i,
    output op_e        op_o
);

    always_comb begin
        op_o = OP_STRAY;
        if (byte_i >= CMD_FLOOR) begin
            // command range always wins over a pending parameter
            case (byte_i)
                CMD_SET_LED:  op_o = OP_SET_LED;
                CMD_ECHO:     op_o = OP_ECHO;
                CMD_SET_RATE: op_o = OP_SET_RATE;
                CMD_ENABLE:   op_o = OP_ENABLE;
                CMD_DISABLE:  op_o = OP_DISABLE;
                CMD_DEFAULTS: op_o = OP_DEFAULTS;
                CMD_RESEND:   op_o = OP_RESEND;
                CMD_RESET:    op_o = OP_RESET;
                default:      op_o = OP_NOP;
            endcase
        end else begin
            case (pend_i)
                PEND_LED:  op_o = OP_LED_ARG;
                PEND_RATE: op_o = OP_RATE_ARG;
                default:   op_o = OP_STRAY;
            endcase
        end
    end

endmodule

// File: rtl/kbd_rsp_queue.sv
`timescale 1ns/1ps
module kbd_rsp_queue #(
    parameter int DEPTH   = 8,   // power of two
    parameter int WIDTH   = 8,
    parameter int MAXPUSH = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(MAXPUSH+1)-1:0]   push_cnt,
    input  logic [MAXPUSH-1:0][WIDTH-1:0]  push_data,
    input  logic                           pop,
    output logic [WIDTH-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(MAXPUSH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               rd;
        logic [CW-1:0]               cnt;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        for (int i = 0; i < MAXPUSH; i++) begin
            if (NW'(i) < push_cnt) begin
                q_d.mem[PW'(q_q.rd + PW'(q_q.cnt) + PW'(i))] = push_data[i];
            end
        end
        if (pop) begin
            q_d.rd = q_q.rd + 1'b1;
        end
        q_d.cnt = q_q.cnt + CW'(push_cnt) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head  = q_q.mem[q_q.rd];
    assign count = q_q.cnt;

endmodule

// File: rtl/kbd_cmd_responder.sv
`timescale 1ns/1ps
module kbd_cmd_responder
    import kbd_cmd_pkg::*;
#(
    parameter int                DEPTH    = 8,
    parameter int                RATE_W   = 7,
    parameter logic [RATE_W-1:0] DEF_RATE = 7'h2B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_data,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    input  logic              rsp_ready,
    input  logic              scan_valid,
    input  logic [7:0]        scan_data,
    output logic [LED_W-1:0]  leds,
    output logic [RATE_W-1:0] typematic,
    output logic              kbd_enabled
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(MAX_PUSH + 1);

    typedef struct packed {
        logic [LED_W-1:0]  leds;
        logic [RATE_W-1:0] rate;
        logic              en;
        logic [7:0]        last;
        pend_e             pend;
    } st_t;

    st_t st_d, st_q;

    op_e                          op;
    logic [CW-1:0]                cnt;
    logic [CW-1:0]                free;
    logic                         fire;
    logic                         pop;
    logic [NW-1:0]                pcnt;
    logic [MAX_PUSH-1:0][7:0]     pdat;

    kbd_cmd_decode u_decode (
        .byte_i (cmd_data),
        .pend_i (st_q.pend),
        .op_o   (op)
    );

    kbd_rsp_queue #(
        .DEPTH   (DEPTH),
        .WIDTH   (8),
        .MAXPUSH (MAX_PUSH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_cnt  (pcnt),
        .push_data (pdat),
        .pop       (pop),
        .head      (rsp_data),
        .count     (cnt)
    );

    assign free      = CW'(DEPTH) - cnt;
    assign cmd_ready = (free >= CW'(2));
    assign fire      = cmd_valid && cmd_ready;
    assign rsp_valid = (cnt != '0);
    assign pop       = rsp_valid && rsp_ready;

    always_comb begin
        st_d = st_q;
        pcnt = '0;
        pdat = '0;

        if (fire) begin
            st_d.pend = PEND_NONE;
            pdat[0]   = RSP_ACK;
            pcnt      = NW'(1);
            case (op)
                OP_LED_ARG:  st_d.leds = cmd_data[LED_W-1:0];
                OP_RATE_ARG: st_d.rate = cmd_data[RATE_W-1:0];
                OP_SET_LED:  st_d.pend = PEND_LED;
                OP_SET_RATE: st_d.pend = PEND_RATE;
                OP_ECHO:     pdat[0]   = RSP_ECHO;
                OP_ENABLE:   st_d.en   = 1'b1;
                OP_DISABLE: begin
                    st_d.en   = 1'b0;
                    st_d.rate = DEF_RATE;
                end
                OP_DEFAULTS: st_d.rate = DEF_RATE;
                OP_RESEND:   pdat[0]   = st_q.last;
                OP_RESET: begin
                    st_d.leds = '0;
                    st_d.rate = DEF_RATE;
                    st_d.en   = 1'b1;
                    st_d.last = '0;
                    pdat[1]   = RSP_BAT;
                    pcnt      = NW'(2);
                end
                default: ;
            endcase
        end

        // scancode goes behind this cycle's command answers
        if (scan_valid && st_q.en && (free > CW'(pcnt))) begin
            pdat[pcnt] = scan_data;
            pcnt       = pcnt + NW'(1);
            st_d.last  = scan_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.leds <= '0;
            st_q.rate <= DEF_RATE;
            st_q.en   <= 1'b1;
            st_q.last <= '0;
            st_q.pend <= PEND_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign leds        = st_q.leds;
    assign typematic   = st_q.rate;
    assign kbd_enabled = st_q.en;

endmodule

// File: rtl/kbd_cmd_responder_chk.sv
`timescale 1ns/1ps
module kbd_cmd_responder_chk #(
    parameter int                RATE_W   = 7,
    parameter logic [RATE_W-1:0] DEF_RATE = 7'h2B
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [7:0]        cmd_data,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic [7:0]        rsp_data,
    input logic              rsp_ready,
    input logic [2:0]        leds,
    input logic [RATE_W-1:0] typematic,
    input logic              kbd_enabled
);

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

    p_leds_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(leds));

    p_rate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(typematic));

    p_en_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(kbd_enabled));

    p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_data == 8'hF4 |=> kbd_enabled);

    p_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_data == 8'hF5
        |=> !kbd_enabled && typematic == DEF_RATE);

    p_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_data == 8'hEE |=> rsp_valid);

    p_reset_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_data == 8'hFF
        |=> kbd_enabled && leds == 3'b000 && typematic == DEF_RATE && rsp_valid);

endmodule

bind kbd_cmd_responder kbd_cmd_responder_chk #(
    .RATE_W   (RATE_W),
    .DEF_RATE (DEF_RATE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_data    (cmd_data),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_ready   (rsp_ready),
    .leds        (leds),
    .typematic   (typematic),
    .kbd_enabled (kbd_enabled)
);

// File: tb/kbd_cmd_responder_bench.sv
`timescale 1ns/1ps
module kbd_cmd_responder_bench;

    localparam int         DEPTH = 4;
    localparam logic [6:0] DEF   = 7'h2B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_ready;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_ready = 1'b0;
    logic       scan_valid = 1'b0;
    logic [7:0] scan_data = '0;
    logic [2:0] leds;
    logic [6:0] typematic;
    logic       kbd_enabled;

    always #2.5 clk = ~clk;

    kbd_cmd_responder #(
        .DEPTH    (DEPTH),
        .RATE_W   (7),
        .DEF_RATE (DEF)
    ) u_kbd_cmd_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .cmd_ready   (cmd_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_ready   (rsp_ready),
        .scan_valid  (scan_valid),
        .scan_data   (scan_data),
        .leds        (leds),
        .typematic   (typematic),
        .kbd_enabled (kbd_enabled)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string req   = "R1";

    // behavioural reference
    int m_q[$];
    int m_leds, m_rate, m_en, m_last, m_pend;   // pend: 0 none, 1 leds, 2 rate

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("rsp_valid", int'(rsp_valid), int'(m_q.size() > 0));
        if (m_q.size() > 0) chk("rsp_data", int'(rsp_data), m_q[0]);
        chk("cmd_ready", int'(cmd_ready), int'((DEPTH - m_q.size()) >= 2));
        chk("leds", int'(leds), m_leds);
        chk("typematic", int'(typematic), m_rate);
        chk("kbd_enabled", int'(kbd_enabled), m_en);
    endtask

    task automatic model_step(bit cv, int cd, bit sv, int sd, bit rr);
        int free;
        int en_old;
        int np[$];
        free   = DEPTH - m_q.size();
        en_old = m_en;
        if (rr && m_q.size() > 0) void'(m_q.pop_front());
        if (cv && free >= 2) begin
            if (cd >= 'hED) begin
                m_pend = 0;
                if (cd == 'hED) begin m_pend = 1; np.push_back('hFA); end
                else if (cd == 'hEE) np.push_back('hEE);
                else if (cd == 'hF3) begin m_pend = 2; np.push_back('hFA); end
                else if (cd == 'hF4) begin m_en = 1; np.push_back('hFA); end
                else if (cd == 'hF5) begin m_en = 0; m_rate = DEF; np.push_back('hFA); end
                else if (cd == 'hF6) begin m_rate = DEF; np.push_back('hFA); end
                else if (cd == 'hFE) np.push_back(m_last);
                else if (cd == 'hFF) begin
                    m_leds = 0; m_rate = DEF; m_en = 1; m_last = 0;
                    np.push_back('hFA); np.push_back('hAA);
                end
                else np.push_back('hFA);
            end else begin
                if (m_pend == 1) m_leds = cd & 7;
                else if (m_pend == 2) m_rate = cd & 'h7F;
                m_pend = 0;
                np.push_back('hFA);
            end
        end
        if (sv && en_old != 0 && free > np.size()) begin
            np.push_back(sd);
            m_last = sd;
        end
        foreach (np[i]) m_q.push_back(np[i]);
    endtask

    task automatic step(bit cv, int cd, bit sv, int sd, bit rr);
        @(negedge clk);
        compare();
        cmd_valid  = cv;
        cmd_data   = cd[7:0];
        scan_valid = sv;
        scan_data  = sd[7:0];
        rsp_ready  = rr;
        model_step(cv, cd, sv, sd, rr);
    endtask

    task automatic cmd(int b);
        step(1'b1, b, 1'b0, 0, 1'b1);
    endtask

    task automatic idle(int n, bit rr = 1'b1);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, rr);
    endtask

    initial begin
        m_leds = 0; m_rate = DEF; m_en = 1; m_last = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        req = "R1"; idle(2);
        req = "R2"; cmd('hED); cmd('h05); idle(3);
        req = "R3"; cmd('hF3); cmd('h85); idle(3);
        req = "R4"; cmd('hEE); idle(2);
        req = "R5"; cmd('hF5); idle(1); cmd('hF3); cmd('h10); cmd('hF6); cmd('hF4); idle(3);
        req = "R6"; cmd('hF0); cmd('hFA); cmd('hF7); cmd('h12); idle(3);
        req = "R7"; cmd('hFE); step(1'b0, 0, 1'b1, 'h1C, 1'b1); cmd('hFE); idle(3);
        req = "R9"; cmd('hED); cmd('hF4); cmd('h06); cmd('hF3); cmd('hED); cmd('h03); idle(3);
        req = "R8"; cmd('hF3); step(1'b1, 'hFF, 1'b1, 'h21, 1'b1); cmd('h04); idle(4);
        req = "R12";
        step(1'b1, 'hF5, 1'b1, 'h2A, 1'b1);
        step(1'b0, 0, 1'b1, 'h2B, 1'b1);
        cmd('hFE);
        cmd('hF4);
        step(1'b0, 0, 1'b1, 'h2C, 1'b1);
        cmd('hFE); idle(3);
        req = "R10";
        for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b1, 'h40 + i, 1'b0);
        step(1'b1, 'hFE, 1'b1, 'h50, 1'b0);
        idle(6);
        cmd('hFE); idle(3);
        req = "R11";
        for (int i = 0; i < 5; i++) step(1'b1, 'hEE, 1'b0, 0, 1'b0);
        idle(2, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 0, 1'b1, 'h60 + i, i[0]);
        idle(6);
        for (int i = 0; i < 400; i++) begin
            int b;
            b = ($urandom_range(0, 1) == 0) ? int'($urandom_range('hED, 'hFF))
                                            : int'($urandom_range(0, 'hFF));
            step($urandom_range(0, 1) == 1, b,
                 $urandom_range(0, 9) < 3, int'($urandom_range(1, 'hFF)),
                 $urandom_range(0, 9) < 7);
        end
        idle(6);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL %s watchdog actual=%0d expected=%0d", req, 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule